// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable integer ratio of the form N = B·P + A. A prescaler counts input cycles and can divide by P or by P+1. A swallow counter holds A, and a main counter holds B. At the start of each output period the prescaler runs in its long modulus (P+1) for A prescaler cycles. It then runs in its short modulus (P) for the remaining B−A cycles. When the main counter reaches terminal count, the block emits a single one-cycle pulse for a downstream phase comparator, and every counter reloads.

The ratio inputs are plain control pins and are sampled only at a period boundary, so a change never produces a short or stretched period. Two hold inputs keep the counters in their load state and keep the output quiet: a counter-reset pin and a power-down pin. If a configuration is out of range, the block clamps it to a legal one and raises an error flag. Ratios are fully contiguous only when N is at least P² − P. Choosing N in that range is left to the system. The block has no streaming data path, so no valid/ready handshake or back-pressure applies.

Top module: `swallow_divider`

## Requirements
- R1: In steady state, `div_pulse` is high for exactly one clock once every N = B·P + A clock cycles, where A and B are the values after clamping.
- R2: The `psel` encoding sets the prescaler base P: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32, and 2'b11 also gives 32. The long modulus is always P+1.
- R3: With A = 0, the period is exactly B·P. With A = B, every prescaler cycle uses the long modulus, so the period is B·(P+1).
- R4: If `a_val` > `b_val`, A is clamped to the effective B and `cfg_err` reads 1 while that configuration is in use.
- R5: If `b_val` < 3, B is treated as 3 and `cfg_err` reads 1 while that configuration is in use.
- R6: While `cnt_rst` is 1, the counters stay in their load state and `div_pulse` stays 0. After `cnt_rst` falls, the first pulse appears after the N-th rising edge at which no hold is active.
- R7: `pwr_dn` has the same hold effect as `cnt_rst`: the output stays quiet, and the first pulse after release comes N cycles later.
- R8: A, B and P values that change during a period do not alter that period. They take effect from the period that starts after the next pulse.
- R9: After `rst_n` is asserted, `div_pulse` and `cfg_err` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Active-high counter hold |
| pwr_dn | input | 1 | Active-high power-down hold |
| psel | input | 2 | Prescaler base select |
| a_val | input | 5 | Swallow count A |
| b_val | input | 13 | Main count B |
| div_pulse | output | 1 | One-cycle pulse per output period |
| cfg_err | output | 1 | Clamped configuration in use |

## Verification
The assertions place no limits on `a_val`, `b_val` or `psel`. Clamping happens before any counter loads, so the ordering between the swallow and main counters and the prescaler range hold for every input pattern. The only assumption the assertions make is that `rst_n` is low at time zero. The stimulus draws B from a small range so that each period stays short. It reaches the illegal regions (A above B, and B below 3) through directed cases. All inputs change only on falling edges.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  localparam int PRE_W = 6;

  typedef enum logic [1:0] {
    PSEL_8   = 2'd0,
    PSEL_16  = 2'd1,
    PSEL_32  = 2'd2,
    PSEL_32X = 2'd3
  } psel_e;

  function automatic logic [PRE_W-1:0] base_modulus(input logic [1:0] sel);
    case (psel_e'(sel))
      PSEL_8:  base_modulus = PRE_W'(8);
      PSEL_16: base_modulus = PRE_W'(16);
      default: base_modulus = PRE_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/swdiv_cfg.sv
module swdiv_cfg
  import swdiv_pkg::*;
#(
  parameter int A_W   = 5,
  parameter int B_W   = 13,
  parameter int B_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       psel_in,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  output logic [A_W-1:0]   a_eff,
  output logic [B_W-1:0]   b_eff,
  output logic [PRE_W-1:0] p_act,
  output logic             err_q
);

  localparam logic [B_W-1:0] B_FLOOR = B_W'(B_MIN);
  localparam int CW = (A_W > B_W) ? A_W : B_W;

  logic b_low, a_high;

  always_comb begin
    b_low  = (b_in < B_FLOOR);
    b_eff  = b_low ? B_FLOOR : b_in;
    a_high = (CW'(a_in) > CW'(b_eff));
    a_eff  = a_high ? A_W'(b_eff) : a_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_act <= PRE_W'(8);
      err_q <= 1'b0;
    end else if (load) begin
      p_act <= base_modulus(psel_in);
      err_q <= b_low | a_high | (CW'(a_in) > CW'(b_in));
    end
  end

  // R2
  p_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_act == PRE_W'(8)) || (p_act == PRE_W'(16)) || (p_act == PRE_W'(32)));

endmodule

// File: rtl/swdiv_presc.sv
module swdiv_presc
  import swdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PRE_W-1:0] p_base,
  input  logic             mod_hi,
  output logic             wrap
);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] last;

  always_comb begin
    last = mod_hi ? p_base : (p_base - PRE_W'(1));
    wrap = (cnt == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= '0;
    else if (wrap)   cnt <= '0;
    else             cnt <= cnt + PRE_W'(1);
  end

  // R2
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= p_base);

endmodule

// File: rtl/swdiv_swallow.sv
module swdiv_swallow #(
  parameter int A_W   = 5,
  parameter int B_W   = 13,
  parameter int B_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           wrap,
  input  logic [A_W-1:0] a_load,
  input  logic [B_W-1:0] b_load,
  output logic           mod_hi,
  output logic           tc
);

  localparam int CW = (A_W > B_W) ? A_W : B_W;

  logic [A_W-1:0] a_left;
  logic [B_W-1:0] b_left;

  always_comb begin
    mod_hi = (a_left != '0);
    tc     = !hold && wrap && (b_left == B_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_left <= '0;
      b_left <= B_W'(B_MIN);
    end else if (hold || tc) begin
      a_left <= a_load;
      b_left <= b_load;
    end else if (wrap) begin
      b_left <= b_left - B_W'(1);
      if (mod_hi) a_left <= a_left - A_W'(1);
    end
  end

  // R4
  swallow_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(a_left) <= CW'(b_left));

  // R5
  b_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_left != '0);

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int A_W   = 5,
  parameter int B_W   = 13,
  parameter int B_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_rst,
  input  logic           pwr_dn,
  input  logic [1:0]     psel,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  output logic           div_pulse,
  output logic           cfg_err
);

  logic             hold;
  logic             tc;
  logic             load;
  logic             wrap;
  logic             mod_hi;
  logic [A_W-1:0]   a_eff;
  logic [B_W-1:0]   b_eff;
  logic [PRE_W-1:0] p_act;

  assign hold = cnt_rst | pwr_dn;
  assign load = hold | tc;

  swdiv_cfg #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .psel_in (psel),
    .a_in    (a_val),
    .b_in    (b_val),
    .a_eff   (a_eff),
    .b_eff   (b_eff),
    .p_act   (p_act),
    .err_q   (cfg_err)
  );

  swdiv_presc u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .p_base (p_act),
    .mod_hi (mod_hi),
    .wrap   (wrap)
  );

  swdiv_swallow #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_swallow (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .wrap   (wrap),
    .a_load (a_eff),
    .b_load (b_eff),
    .mod_hi (mod_hi),
    .tc     (tc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_pulse <= 1'b0;
    else        div_pulse <= tc;
  end

  // R1
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rst || pwr_dn) |=> !div_pulse);

endmodule

// File: tb/tb_swallow_divider.sv
module tb_swallow_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_rst = 1'b1;
  logic        pwr_dn = 1'b0;
  logic [1:0]  psel = 2'd0;
  logic [4:0]  a_val = 5'd0;
  logic [12:0] b_val = 13'd3;
  logic        div_pulse;
  logic        cfg_err;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  swallow_divider dut (
    .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
    .psel(psel), .a_val(a_val), .b_val(b_val),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  function automatic int p_of(input int s);
    return (s == 0) ? 8 : (s == 1) ? 16 : 32;
  endfunction

  function automatic int n_of(input int s, input int a, input int b);
    int be = (b < 3) ? 3 : b;
    int ae = (a > be) ? be : a;
    return be * p_of(s) + ae;
  endfunction

  function automatic int err_of(input int a, input int b);
    return ((b < 3) || (a > b)) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!div_pulse && n < 70000);
  endtask

  task automatic start(input int s, input int a, input int b);
    @(negedge clk);
    psel = 2'(s); a_val = 5'(a); b_val = 13'(b); cnt_rst = 1'b1;
    @(negedge clk);
    cnt_rst = 1'b0;
  endtask

  task automatic run_cfg(input string req, input int s, input int a, input int b);
    int n;
    int e = n_of(s, a, b);
    start(s, a, b);
    check({req, " cfg_err"}, int'(cfg_err), err_of(a, b));
    wait_pulse(n);
    check({req, " first period"}, n, e);
    wait_pulse(n);
    check({req, " steady period"}, n, e);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected<=190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int np;
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 div_pulse", int'(div_pulse), 0);
    check("R9 cfg_err", int'(cfg_err), 0);
    rst_n = 1'b1;

    // R1 R2 directed base values
    run_cfg("R1 R2 p8",  0, 0, 3);
    run_cfg("R2 p16",    1, 9, 20);
    run_cfg("R2 p32",    2, 31, 100);
    run_cfg("R2 sel3",   3, 4, 7);
    run_cfg("R1 long",   0, 7, 500);
    // R3 extremes of A
    run_cfg("R3 a0",     1, 0, 12);
    run_cfg("R3 a_eq_b", 0, 10, 10);
    // R4 clamp
    run_cfg("R4 a_gt_b", 1, 5, 3);
    // R5 small B
    run_cfg("R5 b1",     0, 2, 1);
    run_cfg("R5 b0",     2, 0, 0);

    // R1 constrained random
    for (int i = 0; i < 12; i++) begin
      int s = int'($urandom_range(0, 3));
      int b = int'($urandom_range(3, 40));
      int a = int'($urandom_range(0, (b < 31) ? b : 31));
      run_cfg("R1 random", s, a, b);
    end

    // R8 mid-period change
    start(0, 3, 6);
    wait_pulse(n);
    check("R8 first", n, n_of(0, 3, 6));
    repeat (10) @(posedge clk);
    @(negedge clk);
    psel = 2'd1; a_val = 5'd2; b_val = 13'd5;
    wait_pulse(n);
    check("R8 old period kept", n + 10, n_of(0, 3, 6));
    wait_pulse(n);
    check("R8 new period", n, n_of(1, 2, 5));
    check("R8 cfg_err", int'(cfg_err), 0);

    // R7 power-down hold
    start(1, 4, 6);
    wait_pulse(n);
    repeat (5) @(posedge clk);
    @(negedge clk);
    pwr_dn = 1'b1;
    np = 0;
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); #1;
      if (div_pulse) np++;
    end
    check("R7 quiet", np, 0);
    @(negedge clk);
    pwr_dn = 1'b0;
    wait_pulse(n);
    check("R7 release", n, n_of(1, 4, 6));

    // R6 counter-reset hold, with a new config set while held
    wait_pulse(n);
    repeat (7) @(posedge clk);
    @(negedge clk);
    cnt_rst = 1'b1;
    psel = 2'd0; a_val = 5'd20; b_val = 13'd4;
    np = 0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); #1;
      if (div_pulse) np++;
    end
    check("R6 quiet", np, 0);
    check("R4 cfg_err held", int'(cfg_err), 1);
    @(negedge clk);
    cnt_rst = 1'b0;
    wait_pulse(n);
    check("R6 release", n, n_of(0, 20, 4));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule